// File: doc/BRIEF.md
# Two-Tier DMA Channel Arbiter

This block decides which DMA channel owns the single bus master. Each channel presents a request bit, an enable bit and a 2-bit software priority. When the bus is free, or when the owning channel reports that its current item is done, the arbiter picks a new owner. The channel with the highest software level wins. Among channels on the same level, the lowest channel index wins. The result is a registered one-hot grant, together with a busy flag.

The grant stays fixed while a transfer is in progress. New requests, withdrawn requests and priority changes take effect only at the next decision point. Decision points are an idle bus or a `done_i` pulse. The number of channels is a parameter and defaults to seven.

Top module: `dma_prio_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set in every cycle.
- R2: Channel i's level is `prio_i[2i+1:2i]`. The level values are 3 (very high), 2 (high), 1 (medium) and 0 (low). Among the enabled requesters, a channel with a strictly higher level is granted ahead of every channel with a lower level.
- R3: When several enabled requesters share the top level, the one with the lowest index is granted.
- R4: A channel whose `en_i` bit is 0 is never granted, whatever its request or level.
- R5: After a decision point that finds no enabled request, `grant_o` is all zeros and `busy_o` is low.
- R6: While `busy_o` is high and `done_i` is low, `grant_o` does not change. Requests, enables and levels have no effect on it during that time.
- R7: When `done_i` is high at a clock edge, the grant after that edge is the arbitration result over the inputs at that edge. This result may be the same channel again.
- R8: From idle, an enabled request is granted at the next clock edge, and `busy_o` is high in the same cycle as the grant.
- R9: During and directly after reset, `grant_o` is zero and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_CH | Request bit per channel |
| en_i | input | NUM_CH | Channel enable per channel |
| prio_i | input | 2*NUM_CH | Software level per channel, 2 bits each |
| done_i | input | 1 | Current item of the granted channel finishes |
| grant_o | output | NUM_CH | One-hot bus grant, or zero when idle |
| busy_o | output | 1 | A channel holds the bus |

## Verification
The bench sets levels so that a higher-index channel must beat lower-index ones, and sets ties where only the index decides. A design that ignored levels, or broke ties the wrong way, would grant the wrong bit. It disables the channel that would otherwise win. A design that skipped the enable mask would grant that channel. It raises a more urgent request and withdraws the owner's request during a transfer. A design that re-arbitrated early would switch owners before `done_i`. It also pulses `done_i` with nothing pending, which catches a grant that is not cleared or a busy flag that stays high.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_LOW   = 2'd0;
  localparam lvl_t LVL_VHIGH = 2'd3;
endpackage

// File: rtl/arb_req_mask.sv
module arb_req_mask #(
  parameter int unsigned NUM_CH = 7
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] live_o,
  output logic              any_o
);
  // R4: disabled channels never reach the level stage
  assign live_o = req_i & en_i;
  assign any_o  = |live_o;
endmodule

// File: rtl/arb_level_pick.sv
module arb_level_pick
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic [NUM_CH-1:0]       live_i,
  input  logic [NUM_CH*LVL_W-1:0] prio_i,
  output lvl_t                    top_lvl_o,
  output logic [NUM_CH-1:0]       cand_o
);
  lvl_t lvl [NUM_CH];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_lvl
      assign lvl[g] = prio_i[g*LVL_W +: LVL_W];
    end
  endgenerate

  // Highest level present among live requesters (R2)
  function automatic lvl_t max_level(input logic [NUM_CH-1:0] live,
                                     input lvl_t levels [NUM_CH]);
    lvl_t best = LVL_LOW;
    for (int i = 0; i < NUM_CH; i++)
      if (live[i] && levels[i] > best) best = levels[i];
    return best;
  endfunction

  assign top_lvl_o = max_level(live_i, lvl);

  generate
    for (g = 0; g < NUM_CH; g++) begin : g_cand
      assign cand_o[g] = live_i[g] && (lvl[g] == top_lvl_o);
    end
  endgenerate
endmodule

// File: rtl/arb_first_pick.sv
module arb_first_pick #(
  parameter int unsigned NUM_CH = 7
) (
  input  logic [NUM_CH-1:0] cand_i,
  output logic [NUM_CH-1:0] pick_o
);
  // R3: lowest index among equal-level candidates
  function automatic logic [NUM_CH-1:0] lowest_bit(input logic [NUM_CH-1:0] v);
    logic [NUM_CH-1:0] r = '0;
    logic found = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (v[i] && !found) begin
        r[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  assign pick_o = lowest_bit(cand_i);
endmodule

// File: rtl/arb_grant_hold.sv
module arb_grant_hold #(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rearb_i,
  input  logic [NUM_CH-1:0] pick_i,
  output logic [NUM_CH-1:0] grant_o
);
  logic [NUM_CH-1:0] grant_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      grant_q <= '0;
    else if (rearb_i) grant_q <= pick_i;
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       req_i,
  input  logic [NUM_CH-1:0]       en_i,
  input  logic [NUM_CH*LVL_W-1:0] prio_i,
  input  logic                    done_i,
  output logic [NUM_CH-1:0]       grant_o,
  output logic                    busy_o
);
  // Internal events, named for the checker
  logic [NUM_CH-1:0] req_live;
  logic              req_any;
  lvl_t              lvl_top;
  logic [NUM_CH-1:0] cand_vec;
  logic [NUM_CH-1:0] pick_onehot;
  logic              rearb_en;
  logic [NUM_CH-1:0] grant_q;

  arb_req_mask #(.NUM_CH(NUM_CH)) u_mask (
    .req_i (req_i),
    .en_i  (en_i),
    .live_o(req_live),
    .any_o (req_any)
  );

  arb_level_pick #(.NUM_CH(NUM_CH)) u_lvl (
    .live_i   (req_live),
    .prio_i   (prio_i),
    .top_lvl_o(lvl_top),
    .cand_o   (cand_vec)
  );

  arb_first_pick #(.NUM_CH(NUM_CH)) u_first (
    .cand_i(cand_vec),
    .pick_o(pick_onehot)
  );

  // Decide only when the bus is free or the owner finishes its item
  assign rearb_en = !(|grant_q) || done_i;

  arb_grant_hold #(.NUM_CH(NUM_CH)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rearb_i(rearb_en),
    .pick_i (pick_onehot),
    .grant_o(grant_q)
  );

  assign grant_o = grant_q;
  assign busy_o  = |grant_q;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_CH-1:0]       en_i,
  input logic [NUM_CH*LVL_W-1:0] prio_i,
  input logic                    done_i,
  input logic [NUM_CH-1:0]       grant_o,
  input logic                    busy_o,
  input logic [NUM_CH-1:0]       req_live,
  input logic                    req_any,
  input logic [NUM_CH-1:0]       pick_onehot,
  input logic                    rearb_en
);
  // The picked channel is not beaten by any live requester, and no
  // lower-index live requester has the same level
  logic pick_ok;
  always_comb begin
    int unsigned w;
    lvl_t wl;
    w = 0;
    for (int i = 0; i < NUM_CH; i++) if (pick_onehot[i]) w = i;
    wl = prio_i[w*LVL_W +: LVL_W];
    pick_ok = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req_live[i] && prio_i[i*LVL_W +: LVL_W] > wl) pick_ok = 1'b0;
      if (req_live[i] && i < w && prio_i[i*LVL_W +: LVL_W] == wl) pick_ok = 1'b0;
    end
  end

  a_r1_grant_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  a_r2_r3_pick_is_best: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_any |-> (pick_ok && $onehot(pick_onehot)));

  a_r4_enabled_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearb_en |=> ((grant_o & ~$past(en_i)) == '0));

  a_r5_idle_when_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearb_en && !req_any) |=> (grant_o == '0 && !busy_o));

  a_r6_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> $stable(grant_o));

  a_r7_r8_take_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearb_en |=> (grant_o == $past(pick_onehot)));

  a_r8_busy_with_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearb_en && req_any) |=> busy_o);
endmodule

bind dma_prio_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .prio_i     (prio_i),
  .done_i     (done_i),
  .grant_o    (grant_o),
  .busy_o     (busy_o),
  .req_live   (req_live),
  .req_any    (req_any),
  .pick_onehot(pick_onehot),
  .rearb_en   (rearb_en)
);

// File: tb/sim_dma_prio_arbiter.sv
`timescale 1ns/1ps
module sim_dma_prio_arbiter;
  localparam int N = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] en = '0;
  logic [2*N-1:0] prio = '0;
  logic         done = 1'b0;
  logic [N-1:0] grant;
  logic         busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_prio_arbiter #(.NUM_CH(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_i(en),
    .prio_i(prio), .done_i(done), .grant_o(grant), .busy_o(busy)
  );

  typedef struct packed {
    logic [6:0]  rq;
    logic [6:0]  ena;
    logic [13:0] pr;
    logic [6:0]  exp;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{7'b0000000, 7'h7F, 14'h0000, 7'b0000000},  // R5 nothing pending
    '{7'b0000001, 7'h7F, 14'h0000, 7'b0000001},  // R2 single low
    '{7'b1111111, 7'h7F, 14'h0000, 7'b0000001},  // R3 all tied
    '{7'b1111111, 7'h7F, 14'h0C00, 7'b0100000},  // R2 ch5 very high
    '{7'b1111111, 7'h7F, 14'h1220, 7'b0000100},  // R3 ch2/ch4 high tie
    '{7'b1111111, 7'h7B, 14'h1220, 7'b0010000},  // R4 ch2 disabled
    '{7'b1000000, 7'h7F, 14'h0000, 7'b1000000},  // R2 top index alone
    '{7'b1010000, 7'h7F, 14'h3100, 7'b1000000},  // R2 ch6 beats ch4
    '{7'b1111111, 7'h00, 14'h3FFF, 7'b0000000},  // R4 all disabled
    '{7'b0110110, 7'h7F, 14'h0F3C, 7'b0000010}   // R3 four-way tie
  };

  task automatic check(input string tag, input logic [N-1:0] g_exp, input logic b_exp);
    n_chk++;
    if (grant !== g_exp || busy !== b_exp) begin
      n_bad++;
      $display("FAIL %s: grant=%b busy=%b expected grant=%b busy=%b",
               tag, grant, busy, g_exp, b_exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9 reset
    step(); step();
    check("R9 in reset", '0, 1'b0);
    @(negedge clk); rst_n = 1'b1; req = 7'h7F; en = '0;
    step();
    check("R9 after reset", '0, 1'b0);

    // Table walk: each row is a decision point (done forced high)
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      req = TBL[k].rq; en = TBL[k].ena; prio = TBL[k].pr; done = 1'b1;
      step();
      check($sformatf("R2/R3/R4/R5/R7 row %0d", k), TBL[k].exp, |TBL[k].exp);
    end

    // R5: done with nothing pending clears
    @(negedge clk); req = 7'b0001000; en = 7'h7F; prio = '0; done = 1'b1;
    step();
    check("R7 regrant ch3", 7'b0001000, 1'b1);
    @(negedge clk); req = '0; done = 1'b1;
    step();
    check("R5 cleared on done", '0, 1'b0);

    // R8: from idle, granted next edge without done
    @(negedge clk); done = 1'b0; req = 7'b0001000;
    step();
    check("R8 idle grant", 7'b0001000, 1'b1);

    // R6: more urgent request and withdrawn owner request do not move grant
    @(negedge clk); req = 7'b0001001; prio = 14'h0003;
    step();
    check("R6 hold vs urgent", 7'b0001000, 1'b1);
    @(negedge clk); req = 7'b0000001; en = 7'b0000001;
    step(); step();
    check("R6 hold vs withdrawn", 7'b0001000, 1'b1);

    // R7: done hands bus to ch0
    @(negedge clk); done = 1'b1;
    step();
    check("R7 handover", 7'b0000001, 1'b1);

    // R7: same channel regranted when it stays best
    step();
    check("R7 same channel again", 7'b0000001, 1'b1);

    // R4: owner disabled at decision point loses bus
    @(negedge clk); req = 7'b0000011; en = 7'b0000010; prio = '0;
    step();
    check("R4 masked owner", 7'b0000010, 1'b1);

    // R9: reset mid-transfer
    @(negedge clk); done = 1'b0; rst_n = 1'b0;
    step();
    check("R9 reset while busy", '0, 1'b0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule